// File: doc/BRIEF.md
# Device interrupt delivery mode controller

This block is the interrupt source of a bus function. Internal event pulses, one wire per vector, are turned into either message writes (an address/data pair on a valid/ready output) or a level legacy interrupt line. Two configuration bits pick the delivery mode: a message enable and a legacy disable. With message enable set, the function is in message mode. With it clear, the function uses the legacy line, or only a pollable legacy pending bit when legacy disable is set.

Each vector has a mask bit and a pending bit. A function-wide mask can hold back all vectors at once. Each vector also has an address and data entry written by software. The block keeps a cached copy of each entry. The copy follows the entry while the vector is masked and is frozen while it is unmasked, so every unmask reloads it. Pending vectors are sent lowest index first, and each pending bit clears only when its message is accepted.

Top module: `irq_delivery_ctrl`

## Requirements
- R1: With message enable set (control register at address 0, bit 0), the function is in message mode whatever legacy disable (bit 1) holds. Events set vector pending bits, and legacy_irq_o stays low.
- R2: With message enable 0 and legacy disable 0, events on any vector set legacy_pend_o, and legacy_irq_o equals legacy_pend_o. Vector pending bits are not set.
- R3: With message enable 0 and legacy disable 1, legacy_irq_o stays low while legacy_pend_o still records events.
- R4: An event on a vector whose effective mask is set (its own bit in the mask register at address 1, or the function mask in control bit 2) sets that vector's pending bit and sends no message. Exactly one message is sent for it after the vector is unmasked.
- R5: When a vector's own mask bit clears, its cached address and data are reloaded. A message then carries the entry values written while it was masked (entry i address at register address 2+2i, data at 3+2i).
- R6: Clearing the function mask reloads the cache of every vector whose own mask is clear, in the same way as R5.
- R7: A vector's pending bit clears only when its message is accepted (msg_valid_o and msg_ready_i both high). While msg_ready_i is low, msg_valid_o, msg_addr_o and msg_data_o hold steady.
- R8: When several vectors are pending and unmasked, one message is sent per accepted handshake, in order of increasing vector index.
- R9: Leaving message mode leaves pending vectors pending. No message is started, and no legacy pending or legacy line is raised for them. The message is sent once message mode returns.
- R10: After reset all vector masks are set, the function mask, message enable and legacy disable are 0, and no pending bit, message or legacy line is active.
- R11: A write to the control register with bit 3 set clears legacy_pend_o. The other bits of that write still load the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | NUM_VEC | Event pulses, one per vector |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register address |
| reg_wdata_i | input | 32 | Register write data |
| msg_valid_o | output | 1 | Message write valid |
| msg_ready_i | input | 1 | Message write accepted when high with valid |
| msg_addr_o | output | ADDR_W | Message address |
| msg_data_o | output | DATA_W | Message data |
| legacy_irq_o | output | 1 | Level legacy interrupt line |
| legacy_pend_o | output | 1 | Legacy pending status |
| vec_pend_o | output | NUM_VEC | Per-vector pending status |

## Verification
The bench writes new entry values while a vector is masked and then unmasks it, once through the vector's own mask and once through the function mask. A design without the reload would send the stale address and data. It stalls the handshake and watches the pending bit: a design that clears on issue rather than on acceptance would drop the bit early, and one that lets the output move under a stall would change the data. It raises three vectors at once to catch a wrong priority order, and it switches out of message mode with a vector pending to catch a design that drops the event, converts it to a legacy assertion or keeps sending.

// File: rtl/irq_dlv_pkg.sv
package irq_dlv_pkg;
  localparam int unsigned REG_DW = 32;

  localparam int unsigned CTRL_OFS   = 0;
  localparam int unsigned MASK_OFS   = 1;
  localparam int unsigned ENTRY_BASE = 2;

  localparam int unsigned B_MSG_EN  = 0;
  localparam int unsigned B_LEG_DIS = 1;
  localparam int unsigned B_FMASK   = 2;
  localparam int unsigned B_LEG_CLR = 3;

  typedef struct packed {
    logic msg_en;
    logic leg_dis;
    logic func_mask;
  } dlv_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_dlv_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [REG_AW-1:0]              addr_i,
  input  logic [REG_DW-1:0]              wdata_i,
  output dlv_cfg_t                       cfg_o,
  output logic                           leg_clr_o,
  output logic [NUM_VEC-1:0]             mask_o,
  output logic [NUM_VEC-1:0][ADDR_W-1:0] ent_addr_o,
  output logic [NUM_VEC-1:0][DATA_W-1:0] ent_data_o
);
  logic ctrl_hit, mask_hit;

  assign ctrl_hit  = we_i && (addr_i == REG_AW'(CTRL_OFS));
  assign mask_hit  = we_i && (addr_i == REG_AW'(MASK_OFS));
  assign leg_clr_o = ctrl_hit && wdata_i[B_LEG_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      mask_o <= '1;
    end else begin
      if (ctrl_hit) begin
        cfg_o.msg_en    <= wdata_i[B_MSG_EN];
        cfg_o.leg_dis   <= wdata_i[B_LEG_DIS];
        cfg_o.func_mask <= wdata_i[B_FMASK];
      end
      if (mask_hit) mask_o <= wdata_i[NUM_VEC-1:0];
    end
  end

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_ent
    logic a_hit, d_hit;
    assign a_hit = we_i && (addr_i == REG_AW'(ENTRY_BASE + 2*i));
    assign d_hit = we_i && (addr_i == REG_AW'(ENTRY_BASE + 2*i + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_addr_o[i] <= '0;
        ent_data_o[i] <= '0;
      end else begin
        if (a_hit) ent_addr_o[i] <= wdata_i[ADDR_W-1:0];
        if (d_hit) ent_data_o[i] <= wdata_i[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state #(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           msg_en_i,
  input  logic                           func_mask_i,
  input  logic [NUM_VEC-1:0]             mask_i,
  input  logic [NUM_VEC-1:0]             event_i,
  input  logic [NUM_VEC-1:0]             clr_i,
  input  logic [NUM_VEC-1:0][ADDR_W-1:0] ent_addr_i,
  input  logic [NUM_VEC-1:0][DATA_W-1:0] ent_data_i,
  output logic [NUM_VEC-1:0]             pend_o,
  output logic [NUM_VEC-1:0]             elig_o,
  output logic [NUM_VEC-1:0][ADDR_W-1:0] c_addr_o,
  output logic [NUM_VEC-1:0][DATA_W-1:0] c_data_o
);
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    logic masked;
    assign masked    = mask_i[i] | func_mask_i;
    assign elig_o[i] = pend_o[i] & ~masked & msg_en_i;

    // set wins over clear: a fresh event is never merged into an accepted one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else if (event_i[i] && msg_en_i) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end

    // cache tracks the entry while masked, frozen while unmasked
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_addr_o[i] <= '0;
        c_data_o[i] <= '0;
      end else if (masked) begin
        c_addr_o[i] <= ent_addr_i[i];
        c_data_o[i] <= ent_data_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_msg_out.sv
module irq_msg_out #(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_VEC-1:0]             elig_i,
  input  logic [NUM_VEC-1:0][ADDR_W-1:0] c_addr_i,
  input  logic [NUM_VEC-1:0][DATA_W-1:0] c_data_i,
  output logic [NUM_VEC-1:0]             clr_o,
  output logic                           valid_o,
  input  logic                           ready_i,
  output logic [ADDR_W-1:0]              addr_o,
  output logic [DATA_W-1:0]              data_o
);
  localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] pick_oh, sel_q;
  logic [IDX_W-1:0]   pick_idx;
  logic               found, accept;

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (elig_i[i] && !found) begin
        found      = 1'b1;
        pick_oh[i] = 1'b1;
        pick_idx   = IDX_W'(i);
      end
    end
  end

  assign accept = valid_o && ready_i;
  assign clr_o  = accept ? sel_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sel_q   <= '0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (accept) begin
      valid_o <= 1'b0;
      sel_q   <= '0;
    end else if (!valid_o && found) begin
      valid_o <= 1'b1;
      sel_q   <= pick_oh;
      addr_o  <= c_addr_i[pick_idx];
      data_o  <= c_data_i[pick_idx];
    end
  end
endmodule

// File: rtl/irq_legacy.sv
module irq_legacy #(
  parameter int unsigned NUM_VEC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msg_en_i,
  input  logic               leg_dis_i,
  input  logic               clr_i,
  input  logic [NUM_VEC-1:0] event_i,
  output logic               pend_o,
  output logic               irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else if (!msg_en_i && |event_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  assign irq_o = pend_o & ~msg_en_i & ~leg_dis_i;
endmodule

// File: rtl/irq_delivery_ctrl.sv
module irq_delivery_ctrl
  import irq_dlv_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned REG_AW = $clog2(ENTRY_BASE + 2*NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] event_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [REG_DW-1:0]  reg_wdata_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [ADDR_W-1:0]  msg_addr_o,
  output logic [DATA_W-1:0]  msg_data_o,
  output logic               legacy_irq_o,
  output logic               legacy_pend_o,
  output logic [NUM_VEC-1:0] vec_pend_o
);
  dlv_cfg_t                       cfg;
  logic                           leg_clr;
  logic [NUM_VEC-1:0]             mask, elig, clr;
  logic [NUM_VEC-1:0][ADDR_W-1:0] ent_addr, c_addr;
  logic [NUM_VEC-1:0][DATA_W-1:0] ent_data, c_data;

  irq_cfg_regs #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .leg_clr_o(leg_clr), .mask_o(mask),
    .ent_addr_o(ent_addr), .ent_data_o(ent_data)
  );

  irq_vec_state #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vec (
    .clk_i, .rst_ni,
    .msg_en_i(cfg.msg_en), .func_mask_i(cfg.func_mask), .mask_i(mask),
    .event_i, .clr_i(clr),
    .ent_addr_i(ent_addr), .ent_data_i(ent_data),
    .pend_o(vec_pend_o), .elig_o(elig), .c_addr_o(c_addr), .c_data_o(c_data)
  );

  irq_msg_out #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni,
    .elig_i(elig), .c_addr_i(c_addr), .c_data_i(c_data), .clr_o(clr),
    .valid_o(msg_valid_o), .ready_i(msg_ready_i),
    .addr_o(msg_addr_o), .data_o(msg_data_o)
  );

  irq_legacy #(.NUM_VEC(NUM_VEC)) u_leg (
    .clk_i, .rst_ni,
    .msg_en_i(cfg.msg_en), .leg_dis_i(cfg.leg_dis), .clr_i(leg_clr),
    .event_i, .pend_o(legacy_pend_o), .irq_o(legacy_irq_o)
  );
endmodule

// File: rtl/irq_delivery_chk.sv
module irq_delivery_chk #(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_en,
  input logic               leg_dis,
  input logic               legacy_irq_o,
  input logic               msg_valid_o,
  input logic               msg_ready_i,
  input logic [ADDR_W-1:0]  msg_addr_o,
  input logic [DATA_W-1:0]  msg_data_o,
  input logic [NUM_VEC-1:0] vec_pend_o
);
  p_msg_mode_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_en |-> !legacy_irq_o);

  p_leg_dis_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_en && leg_dis) |-> !legacy_irq_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

  p_clear_on_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(vec_pend_o) & ~vec_pend_o)) |-> $past(msg_valid_o && msg_ready_i));

  p_one_per_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0($past(vec_pend_o) & ~vec_pend_o));

  p_no_start_outside_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_en && !msg_valid_o) |=> !msg_valid_o);
endmodule

bind irq_delivery_ctrl irq_delivery_chk #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_en(cfg.msg_en), .leg_dis(cfg.leg_dis),
  .legacy_irq_o(legacy_irq_o), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o), .vec_pend_o(vec_pend_o)
);

// File: tb/irq_delivery_ctrl_test.sv
module irq_delivery_ctrl_test;
  localparam int NV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] event_i = '0;
  logic          we = 1'b0;
  logic [3:0]    waddr = '0;
  logic [31:0]   wdata = '0;
  logic          valid, ready = 1'b0;
  logic [31:0]   maddr, mdata;
  logic          leg_irq, leg_pend;
  logic [NV-1:0] vpend;

  int n_chk = 0;
  int n_fail = 0;
  logic [NV-1:0] mask_sh = '1;

  always #10 clk = ~clk;

  irq_delivery_ctrl #(.NUM_VEC(NV), .ADDR_W(32), .DATA_W(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .event_i(event_i),
    .reg_we_i(we), .reg_addr_i(waddr), .reg_wdata_i(wdata),
    .msg_valid_o(valid), .msg_ready_i(ready),
    .msg_addr_o(maddr), .msg_data_o(mdata),
    .legacy_irq_o(leg_irq), .legacy_pend_o(leg_pend), .vec_pend_o(vpend)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_mask(input logic [NV-1:0] m);
    mask_sh = m;
    reg_write(4'd1, 32'(m));
  endtask

  task automatic pulse(input logic [NV-1:0] v);
    event_i = v;
    @(negedge clk);
    event_i = '0;
  endtask

  task automatic expect_msg(input string tag, input logic [31:0] ea, input logic [31:0] ed);
    int n = 0;
    while (!valid && n < 20) begin @(negedge clk); n++; end
    check({tag, " valid"}, 32'(valid), 32'd1);
    check({tag, " addr"}, maddr, ea);
    check({tag, " data"}, mdata, ed);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic expect_idle(input string tag, input int cyc);
    logic seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      seen |= valid;
    end
    check({tag, " no message"}, 32'(seen), 32'd0);
  endtask

  function automatic logic [31:0] ea(input int v); return 32'h1000 + 32'(v) * 32'h10; endfunction
  function automatic logic [31:0] ed(input int v); return 32'hA0 + 32'(v); endfunction

  task automatic t_reset();
    check("R10 valid", 32'(valid), 0);
    check("R10 legacy line", 32'(leg_irq), 0);
    check("R10 legacy pend", 32'(leg_pend), 0);
    check("R10 vec pend", 32'(vpend), 0);
    pulse(4'b0001);
    check("R10 masked at reset, no msg mode", 32'(vpend), 0);
    reg_write(4'd0, 32'h8);
    for (int v = 0; v < NV; v++) begin
      reg_write(4'(2 + 2*v), ea(v));
      reg_write(4'(3 + 2*v), ed(v));
    end
  endtask

  task automatic t_legacy();
    reg_write(4'd0, 32'h0);
    pulse(4'b0100);
    check("R2 legacy pend", 32'(leg_pend), 1);
    check("R2 line equals pend", 32'(leg_irq), 1);
    check("R2 no vector pend", 32'(vpend), 0);
    reg_write(4'd0, 32'h8);
    check("R11 pend cleared", 32'(leg_pend), 0);
    check("R2 line follows pend", 32'(leg_irq), 0);
  endtask

  task automatic t_legdis();
    reg_write(4'd0, 32'h2);
    pulse(4'b0010);
    check("R3 pend recorded", 32'(leg_pend), 1);
    check("R3 line low", 32'(leg_irq), 0);
    reg_write(4'd0, 32'h0);
    check("R2 line rises with pend", 32'(leg_irq), 1);
    reg_write(4'd0, 32'h8);
  endtask

  task automatic t_msg_mode();
    reg_write(4'd0, 32'h3);
    set_mask('0);
    pulse(4'b0100);
    check("R1 vec pend", 32'(vpend), 32'b0100);
    check("R1 legacy pend untouched", 32'(leg_pend), 0);
    check("R1 legacy line", 32'(leg_irq), 0);
    expect_msg("R1 msg v2", ea(2), ed(2));
    check("R1 pend cleared", 32'(vpend), 0);
  endtask

  task automatic t_masked();
    set_mask(4'b0010);
    pulse(4'b0010);
    expect_idle("R4 masked", 6);
    check("R4 pend held", 32'(vpend), 32'b0010);
    set_mask('0);
    expect_msg("R4 after unmask", ea(1), ed(1));
    expect_idle("R4 only once", 6);
    check("R4 pend cleared", 32'(vpend), 0);
  endtask

  task automatic t_reload();
    pulse(4'b0001);
    expect_msg("R5 before reload", ea(0), ed(0));
    set_mask(4'b0001);
    reg_write(4'd2, 32'h2000);
    reg_write(4'd3, 32'h55);
    set_mask('0);
    pulse(4'b0001);
    expect_msg("R5 reloaded", 32'h2000, 32'h55);
  endtask

  task automatic t_func_mask();
    reg_write(4'd0, 32'h5);
    reg_write(4'd8, 32'h3000);
    reg_write(4'd9, 32'h66);
    pulse(4'b1000);
    expect_idle("R6 function masked", 6);
    reg_write(4'd0, 32'h1);
    expect_msg("R6 reloaded", 32'h3000, 32'h66);
  endtask

  task automatic t_hold();
    logic [31:0] a0, d0;
    pulse(4'b0001);
    while (!valid) @(negedge clk);
    a0 = maddr; d0 = mdata;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R7 valid held", 32'(valid), 1);
    check("R7 addr held", maddr, a0);
    check("R7 data held", mdata, d0);
    check("R7 pend until accept", 32'(vpend), 32'b0001);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    check("R7 pend after accept", 32'(vpend), 0);
    check("R7 stalled msg data", d0, 32'h55);
  endtask

  task automatic t_priority();
    set_mask('1);
    pulse(4'b1110);
    check("R8 three pending", 32'(vpend), 32'b1110);
    set_mask('0);
    expect_msg("R8 first v1", ea(1), ed(1));
    expect_msg("R8 second v2", ea(2), ed(2));
    expect_msg("R8 third v3", 32'h3000, 32'h66);
    check("R8 all cleared", 32'(vpend), 0);
  endtask

  task automatic t_mode_switch();
    set_mask(4'b0100);
    pulse(4'b0100);
    reg_write(4'd0, 32'h0);
    set_mask('0);
    expect_idle("R9 legacy mode", 6);
    check("R9 still pending", 32'(vpend), 32'b0100);
    check("R9 no legacy pend", 32'(leg_pend), 0);
    check("R9 no legacy line", 32'(leg_irq), 0);
    reg_write(4'd0, 32'h1);
    expect_msg("R9 sent on return", ea(2), ed(2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legacy();
    t_legdis();
    t_msg_mode();
    t_masked();
    t_reload();
    t_func_mask();
    t_hold();
    t_priority();
    t_mode_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule